// File: doc/BRIEF.md
# Prescaled Bus-Stall Wait Timer

This block watches a serial bus engine for stalls. While the engine reports that it is waiting on the bus (for example, for a clock line that a target holds low), a counter advances once per divided tick. If the engine makes no progress before the count passes a programmed limit, the block raises a timeout flag. The flag stays set until software writes a one to its bit in the status word.

Software programs two values. The first is a divider exponent, so that ticks arrive once every 2^k system clocks. The second is a control word that holds a 15-bit limit and an enable bit. A driver may clear the enable around a command launch and then set it again with the same limit. Each control write restarts the count from zero, so the limit is kept and no stale partial count carries over. Progress strobes from the engine, such as a clock edge or a finished byte, also restart the count.

Top module: `bus_stall_timer`

## Requirements
- R1: After reset the timeout flag is low, the enable is clear, the divider exponent is 0 and the count is 0.
- R2: The limit N is taken from control-word bits 14:0. With an exponent of 0, the engine waiting throughout and no restart, the flag rises at the clock edge N+1 edges after the control write. It is still low one edge earlier.
- R3: The enable is control-word bit 15. While it is 0, no amount of waiting raises the flag.
- R4: Every control write restarts the count from zero. Disabling, waiting, and then re-enabling with the same limit gives the full N+1 ticks measured from the re-enabling write.
- R5: With exponent k, ticks come once every 2^k clocks, and the timeout needs (N+1)*2^k edges after a write that sets both values together. Exponents above 14 are treated as 14.
- R6: Writing the exponent resets the tick divider, so the first tick comes exactly 2^k edges after the write.
- R7: A progress strobe restarts the count. The count advances only while the waiting input is high and holds its value while that input is low.
- R8: The flag is sticky. It is cleared only by a status write with bit 7 set, and a status write with bit 7 clear leaves it unchanged.
- R9: After a timeout the flag is not raised again until a progress strobe or a control write has restarted the count.
- R10: When a timeout and a clearing status write fall in the same cycle, the flag ends up set.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_wr | input | 1 | Write strobe for the divider exponent |
| psc_wdata | input | 4 | Divider exponent (log2 of the tick period) |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Bit 15 enable, bits 14:0 limit |
| sts_wr | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 16 | Status write data; bit 7 clears the timeout |
| bus_progress | input | 1 | Progress strobe from the bus engine |
| bus_waiting | input | 1 | High while the engine waits on the bus |
| tmo_flag | output | 1 | Sticky timeout status (bit 7 of the status word) |

## Verification
Two events can fall in the same cycle: an expiry setting the flag and a software write clearing it. The bench arranges this by leaving the flag set and restarting the count with a progress strobe. It then places the clearing write exactly on the edge where the restarted count expires, and expects the flag to stay high. A second case lands a divider write together with a progress strobe at an arbitrary point in the divider's phase. Here the expected timeout edge would come too early if the divider had not restarted.

// File: rtl/bst_pkg.sv
package bst_pkg;
    localparam int CNT_W_DEF   = 15;
    localparam int PSC_W_DEF   = 4;
    localparam int MAX_PSC_DEF = 14;
    localparam int STS_W_DEF   = 16;
    localparam int TMO_BIT_DEF = 7;
endpackage

// File: rtl/bst_prescaler.sv
module bst_prescaler #(
    parameter int PSC_W   = 4,
    parameter int MAX_PSC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psc_wr_i,
    input  logic [PSC_W-1:0] psc_wdata_i,
    output logic             tick_o
);
    localparam logic [PSC_W-1:0] PSC_TOP = PSC_W'(MAX_PSC);

    typedef struct packed {
        logic [PSC_W-1:0]   psc;
        logic [MAX_PSC-1:0] div;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic [MAX_PSC-1:0] span;

    always_comb begin
        span   = (MAX_PSC'(1) << st_q.psc) - MAX_PSC'(1);
        tick_o = (st_q.div == span);
        st_d   = st_q;
        st_d.div = tick_o ? '0 : st_q.div + MAX_PSC'(1);
        if (psc_wr_i) begin
            st_d.div = '0;
            st_d.psc = (psc_wdata_i > PSC_TOP) ? PSC_TOP : psc_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    psc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.psc <= PSC_TOP);

    // R6
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_wr_i |=> (st_q.div == '0 && !$past(tick_o, 1) || st_q.div == '0));
endmodule

// File: rtl/bst_wait_ctr.sv
module bst_wait_ctr #(
    parameter int CNT_W = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ctl_wr_i,
    input  logic [CNT_W:0] ctl_wdata_i,
    input  logic           act_i,
    input  logic           wait_i,
    input  logic           tick_i,
    output logic           expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] lim;
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } wt_st_t;

    wt_st_t st_d, st_q;
    logic   restart;
    logic   step;

    always_comb begin
        restart  = ctl_wr_i | act_i;
        step     = st_q.en & wait_i & tick_i & st_q.armed;
        expire_o = !restart && step && (st_q.cnt == st_q.lim);
        st_d     = st_q;
        if (ctl_wr_i) begin
            st_d.lim = ctl_wdata_i[CNT_W-1:0];
            st_d.en  = ctl_wdata_i[CNT_W];
        end
        if (restart) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (step) begin
            if (st_q.cnt == st_q.lim) st_d.armed = 1'b0;
            else                      st_d.cnt   = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lim   <= '1;
            st_q.en    <= 1'b0;
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);

    // R3
    expire_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> st_q.en);

    // R7
    progress_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> (st_q.cnt == '0 && st_q.armed));

    // R9
    no_double_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !ctl_wr_i && !act_i) |=> !st_q.armed);
endmodule

// File: rtl/bst_tmo_status.sv
module bst_tmo_status #(
    parameter int STS_W   = 16,
    parameter int TMO_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             sts_wr_i,
    input  logic [STS_W-1:0] sts_wdata_i,
    output logic             flag_o
);
    typedef struct packed {
        logic flag;
    } sts_st_t;

    sts_st_t st_d, st_q;
    logic    clr;

    always_comb begin
        clr  = sts_wr_i & sts_wdata_i[TMO_BIT];
        st_d = st_q;
        if (set_i)    st_d.flag = 1'b1;
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R8
    rise_from_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(set_i));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.flag);

    // R8
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_i) |=> !st_q.flag);
endmodule

// File: rtl/bus_stall_timer.sv
module bus_stall_timer
    import bst_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int PSC_W   = PSC_W_DEF,
    parameter int MAX_PSC = MAX_PSC_DEF,
    parameter int STS_W   = STS_W_DEF,
    parameter int TMO_BIT = TMO_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_wdata,
    input  logic             ctl_wr,
    input  logic [CNT_W:0]   ctl_wdata,
    input  logic             sts_wr,
    input  logic [STS_W-1:0] sts_wdata,
    input  logic             bus_progress,
    input  logic             bus_waiting,
    output logic             tmo_flag
);
    logic tick;
    logic expire;

    bst_prescaler #(.PSC_W(PSC_W), .MAX_PSC(MAX_PSC)) u_psc (
        .clk        (clk),
        .rst_n      (rst_n),
        .psc_wr_i   (psc_wr),
        .psc_wdata_i(psc_wdata),
        .tick_o     (tick)
    );

    bst_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr_i   (ctl_wr),
        .ctl_wdata_i(ctl_wdata),
        .act_i      (bus_progress),
        .wait_i     (bus_waiting),
        .tick_i     (tick),
        .expire_o   (expire)
    );

    bst_tmo_status #(.STS_W(STS_W), .TMO_BIT(TMO_BIT)) u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (expire),
        .sts_wr_i   (sts_wr),
        .sts_wdata_i(sts_wdata),
        .flag_o     (tmo_flag)
    );

    // R1
    reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tmo_flag);
endmodule

// File: tb/bus_stall_timer_tb.sv
module bus_stall_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 60000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psc_wr = 1'b0;
    logic [3:0]  psc_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        sts_wr = 1'b0;
    logic [15:0] sts_wdata = '0;
    logic        bus_progress = 1'b0;
    logic        bus_waiting = 1'b0;
    logic        tmo_flag;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    run_cmp = 1'b0;

    // behavioural reference state
    int m_exp, m_div, m_lim, m_cnt;
    bit m_en, m_armed, m_flag;

    bus_stall_timer u_dut (
        .clk(clk), .rst_n(rst_n), .psc_wr(psc_wr), .psc_wdata(psc_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .bus_progress(bus_progress),
        .bus_waiting(bus_waiting), .tmo_flag(tmo_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_exp = 0; m_div = 0; m_lim = 32767; m_en = 0;
            m_cnt = 0; m_armed = 1; m_flag = 0;
        end else begin
            bit tk, adv, fire;
            tk   = (m_div == (1 << m_exp) - 1);
            adv  = m_en && bus_waiting && tk && m_armed;
            fire = !ctl_wr && !bus_progress && adv && (m_cnt == m_lim);
            if (fire) m_flag = 1;
            else if (sts_wr && sts_wdata[7]) m_flag = 0;
            if (ctl_wr || bus_progress) begin
                if (ctl_wr) begin
                    m_lim = int'(ctl_wdata[14:0]);
                    m_en  = ctl_wdata[15];
                end
                m_cnt = 0; m_armed = 1;
            end else if (adv) begin
                if (m_cnt == m_lim) m_armed = 0;
                else m_cnt = m_cnt + 1;
            end
            m_div = tk ? 0 : m_div + 1;
            if (psc_wr) begin
                m_div = 0;
                m_exp = (psc_wdata > 4'd14) ? 14 : int'(psc_wdata);
            end
        end
    end

    always @(negedge clk) begin
        if (run_cmp) chk(tmo_flag == m_flag, cur_req, int'(tmo_flag), int'(m_flag));
    end

    always @(posedge clk) begin
        if (cycles > WDOG_LIMIT) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WDOG_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input bit en, input int lim);
        ctl_wr = 1; ctl_wdata = {en, 15'(lim)};
        cyc(1);
        ctl_wr = 0;
    endtask

    task automatic clear_flag();
        sts_wr = 1; sts_wdata = 16'h0080;
        cyc(1);
        sts_wr = 0; sts_wdata = '0;
    endtask

    task automatic pulse_progress();
        bus_progress = 1;
        cyc(1);
        bus_progress = 0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        run_cmp = 1;
        cur_req = "R1";
        chk(tmo_flag == 0, "R1", int'(tmo_flag), 0);

        // R2: limit 5, exponent 0
        cur_req = "R2";
        bus_waiting = 1;
        write_ctl(1, 5);
        cyc(5);
        chk(tmo_flag == 0, "R2", int'(tmo_flag), 0);
        cyc(1);
        chk(tmo_flag == 1, "R2", int'(tmo_flag), 1);

        // R8: write without bit 7 keeps flag; bit 7 clears it
        cur_req = "R8";
        sts_wr = 1; sts_wdata = 16'hFF7F;
        cyc(1);
        sts_wr = 0; sts_wdata = '0;
        chk(tmo_flag == 1, "R8", int'(tmo_flag), 1);
        clear_flag();
        chk(tmo_flag == 0, "R8", int'(tmo_flag), 0);

        // R9: still waiting, no restart, no second timeout
        cur_req = "R9";
        cyc(40);
        chk(tmo_flag == 0, "R9", int'(tmo_flag), 0);
        pulse_progress();
        cyc(5);
        chk(tmo_flag == 0, "R9", int'(tmo_flag), 0);
        cyc(1);
        chk(tmo_flag == 1, "R9", int'(tmo_flag), 1);

        // R10: expiry and clear in the same cycle
        cur_req = "R10";
        pulse_progress();
        cyc(5);
        sts_wr = 1; sts_wdata = 16'h0080;
        cyc(1);
        sts_wr = 0; sts_wdata = '0;
        chk(tmo_flag == 1, "R10", int'(tmo_flag), 1);
        clear_flag();
        chk(tmo_flag == 0, "R10", int'(tmo_flag), 0);

        // R7: progress strobes keep it alive, waiting low pauses counting
        cur_req = "R7";
        for (int i = 0; i < 10; i++) begin
            cyc(3);
            pulse_progress();
        end
        chk(tmo_flag == 0, "R7", int'(tmo_flag), 0);
        bus_waiting = 0;
        pulse_progress();
        bus_waiting = 1;
        cyc(3);
        bus_waiting = 0;
        cyc(20);
        chk(tmo_flag == 0, "R7", int'(tmo_flag), 0);
        bus_waiting = 1;
        cyc(2);
        chk(tmo_flag == 0, "R7", int'(tmo_flag), 0);
        cyc(1);
        chk(tmo_flag == 1, "R7", int'(tmo_flag), 1);
        clear_flag();

        // R3: disabled timer never times out
        cur_req = "R3";
        write_ctl(0, 2);
        cyc(100);
        chk(tmo_flag == 0, "R3", int'(tmo_flag), 0);

        // R4: disable then re-enable with same limit restarts from zero
        cur_req = "R4";
        write_ctl(1, 4);
        cyc(3);
        write_ctl(0, 4);
        cyc(10);
        chk(tmo_flag == 0, "R4", int'(tmo_flag), 0);
        write_ctl(1, 4);
        cyc(4);
        chk(tmo_flag == 0, "R4", int'(tmo_flag), 0);
        cyc(1);
        chk(tmo_flag == 1, "R4", int'(tmo_flag), 1);
        clear_flag();

        // R5: exponent 2, limit 3 -> 16 edges
        cur_req = "R5";
        psc_wr = 1; psc_wdata = 4'd2;
        write_ctl(1, 3);
        psc_wr = 0;
        cyc(15);
        chk(tmo_flag == 0, "R5", int'(tmo_flag), 0);
        cyc(1);
        chk(tmo_flag == 1, "R5", int'(tmo_flag), 1);
        clear_flag();
        // R5: exponent 15 clamps to 14, limit 0 -> 16384 edges
        psc_wr = 1; psc_wdata = 4'd15;
        write_ctl(1, 0);
        psc_wr = 0;
        cyc(16383);
        chk(tmo_flag == 0, "R5", int'(tmo_flag), 0);
        cyc(1);
        chk(tmo_flag == 1, "R5", int'(tmo_flag), 1);
        clear_flag();

        // R6: divider restarts on exponent write mid-period
        cur_req = "R6";
        bus_waiting = 0;
        psc_wr = 1; psc_wdata = 4'd3;
        write_ctl(1, 1);
        psc_wr = 0;
        cyc(5);
        bus_waiting = 1;
        psc_wr = 1; psc_wdata = 4'd3;
        pulse_progress();
        psc_wr = 0;
        cyc(15);
        chk(tmo_flag == 0, "R6", int'(tmo_flag), 0);
        cyc(1);
        chk(tmo_flag == 1, "R6", int'(tmo_flag), 1);

        run_cmp = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule